// File: doc/BRIEF.md
# Mains-Synchronous Home-Control Command Transmitter

This block sends one house/unit command over the mains wiring as a burst-coded frame. The frame is locked to the zero crossings of the AC line. A host hands it a house code, a key code and a repeat count through a valid/ready handshake. The block then does the following in order:

- It locks onto the crossing signal.
- It leaves three full mains cycles of silence.
- It plays out the frame `repeat` times back to back. Each slot turns the carrier-enable pin on for a fixed burst right after a crossing, or leaves it off.

Every rising or falling transition of the crossing input counts as one crossing. That input passes through a flop synchroniser before edge detection. All timing is counted in ticks of a one-microsecond strobe. The half-cycle length, burst length and sync limits are parameters, so one netlist covers 50 Hz and 60 Hz lines.

The controller has six states:

- `ST_IDLE`: ready for a command. On *accept* it goes to `ST_SYNC`. On *reject* it goes to `ST_FAIL`.
- `ST_SYNC`: waits for a usable crossing. On *lock* it goes to `ST_GUARD`. On *retry* it stays in `ST_SYNC`. On *sync_lost* it goes to `ST_FAIL`.
- `ST_GUARD`: counts the crossings of the silent gap. On *gap_done* it goes to `ST_SLOT`. On *frame_err* it goes to `ST_FAIL`.
- `ST_SLOT`: one half-cycle slot of the frame. On *next_slot* it stays in `ST_SLOT`. On *last_slot* it goes to `ST_FIN`. On *frame_err* it goes to `ST_FAIL`.
- `ST_FIN`: a one-cycle done pulse. On *release* it returns to `ST_IDLE`.
- `ST_FAIL`: a one-cycle error pulse. On *release* it returns to `ST_IDLE`.

Top module: `plc_frame_tx`

## Requirements
- R1: `cmd_ready` is high only in the idle state. A command with `cmd_valid` high while the block is busy is ignored, and the frame in flight continues unchanged.
- R2: A command with house code ≥ 16, key code ≥ 32 or repeat count 0 is rejected. `error` pulses for one cycle on the next cycle, `busy` stays low and no carrier is sent.
- R3: A sync attempt succeeds on a crossing that arrives at least `SYNC_MIN_US` ticks after the attempt began. An attempt with no crossing within `SYNC_TIMEOUT_US` ticks is retried. After `SYNC_TRIES` failed attempts the block raises `error` and returns to idle. A crossing that arrives too soon also ends an attempt, and that attempt counts as failed.
- R4: After the sync crossing, the block counts six more crossings (`GUARD_ZC`) with the carrier low. The sixth of them opens frame slot 0.
- R5: A frame is 22 slots, one per half-cycle. Slots 0–3 carry 1,1,1,0. Slots 4–11 carry the four house pattern bits, most significant first. Slots 12–21 carry the five key pattern bits, most significant first. Each pattern bit is sent as the bit followed by its complement.
- R6: House code h maps to a 4-bit pattern. Written as numbers for h = 0..15, the patterns are 6, 14, 2, 10, 1, 9, 5, 13, 7, 15, 3, 11, 0, 8, 4, 12.
- R7: For a key code k below 16, the 5-bit key pattern is the house pattern of k followed by 0. For k of 16 or more, it is the 4-bit value k−16 followed by 1.
- R8: In a '1' slot, `carrier_en` rises within three clocks of the crossing and stays high for `BURST_US` ticks. In a '0' slot it stays low. The carrier is never on outside the frame.
- R9: The frame is sent `cmd_reps` times with no gap between repeats, so the block sends 22 × `cmd_reps` slots in total.
- R10: In the guard and frame phases, the block checks the interval since the previous crossing. The limits are 72 % and 102 % of `HALF_US`. A crossing that arrives earlier than the lower limit is a framing error. So is a run past the upper limit with no crossing. On a framing error the carrier drops, `error` pulses for one cycle and the block returns to idle. The block does not fault before the upper limit is passed.
- R11: `busy` is high from accept until the end. `done` pulses for one cycle after the crossing that closes the last slot. `done` and `error` are never high together.
- R12: Rising and falling transitions of `zc_in` both count as crossings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| zc_in | input | 1 | Asynchronous mains zero-crossing level |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_house | input | CODE_W | House code, valid range 0..15 |
| cmd_key | input | CODE_W | Key code, valid range 0..31 |
| cmd_reps | input | REP_W | Number of back-to-back frames |
| carrier_en | output | 1 | Carrier burst enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | One-cycle pulse on reject, sync failure or framing error |

## Verification
The bench drives a mains crossing stream that toggles in both directions. A scoreboard predicts the carrier level after every crossing, so a wrong entry in the house or key lookup, a missing complement bit, or an off-by-one in the guard count shows up as a carrier mismatch at a named slot. The bench also tests these corners:

- A crossing arrives early in mid-frame. A design with the wrong lower limit would keep sending.
- The crossing stream stops in mid-frame. A design that faults too early or never faults would be caught by a window check on `error`.
- The crossing input is stuck. A design with a wrong retry limit would report the sync failure at the wrong time.
- Out-of-range codes and a zero repeat count are offered. A design that lacks these checks would start a frame.
- A second command is offered while the block is busy. A design that latches it would corrupt the remaining slots.

// File: rtl/plc_tx_pkg.sv
package plc_tx_pkg;

    localparam int HOUSE_W     = 4;
    localparam int KEY_W       = 5;
    localparam int PREFIX_LEN  = 4;
    localparam int FRAME_SLOTS = PREFIX_LEN + 2 * HOUSE_W + 2 * KEY_W;
    localparam int SLOT_W      = $clog2(FRAME_SLOTS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_GUARD,
        ST_SLOT,
        ST_FIN,
        ST_FAIL
    } tx_state_e;

endpackage

// File: rtl/plc_zc_sync.sv
module plc_zc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic zc_async,
    output logic zc_edge
);
    // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], zc_async};
        end
    end

    assign zc_edge = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/plc_gap_timer.sv
module plc_gap_timer #(
    parameter int LIMIT = 250000,
    parameter int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    output logic [CNT_W-1:0] gap
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (clear) begin
            gap <= '0;
        end else if (tick && gap != SAT) begin
            gap <= gap + 1'b1;
        end
    end

endmodule

// File: rtl/plc_frame_encoder.sv
module plc_frame_encoder
    import plc_tx_pkg::*;
(
    input  logic [HOUSE_W-1:0]     house,
    input  logic [KEY_W-1:0]       key,
    output logic [FRAME_SLOTS-1:0] frame
);
    // slot 0 sits at the most significant bit
    localparam int HOUSE_TOP = FRAME_SLOTS - PREFIX_LEN - 1;
    localparam int KEY_TOP   = 2 * KEY_W - 1;

    function automatic logic [HOUSE_W-1:0] house_pat(input logic [HOUSE_W-1:0] h);
        case (h)
            4'd0:    house_pat = 4'b0110;
            4'd1:    house_pat = 4'b1110;
            4'd2:    house_pat = 4'b0010;
            4'd3:    house_pat = 4'b1010;
            4'd4:    house_pat = 4'b0001;
            4'd5:    house_pat = 4'b1001;
            4'd6:    house_pat = 4'b0101;
            4'd7:    house_pat = 4'b1101;
            4'd8:    house_pat = 4'b0111;
            4'd9:    house_pat = 4'b1111;
            4'd10:   house_pat = 4'b0011;
            4'd11:   house_pat = 4'b1011;
            4'd12:   house_pat = 4'b0000;
            4'd13:   house_pat = 4'b1000;
            4'd14:   house_pat = 4'b0100;
            default: house_pat = 4'b1100;
        endcase
    endfunction

    logic [HOUSE_W-1:0] hp;
    logic [KEY_W-1:0]   kp;

    always_comb begin
        hp = house_pat(house);
        if (key[KEY_W-1]) begin
            kp = {key[KEY_W-2:0], 1'b1};
        end else begin
            kp = {house_pat(key[KEY_W-2:0]), 1'b0};
        end
    end

    assign frame[FRAME_SLOTS-1 -: PREFIX_LEN] = 4'b1110;

    for (genvar i = 0; i < HOUSE_W; i++) begin : g_house_pair
        assign frame[HOUSE_TOP - 2*i]     =  hp[HOUSE_W-1-i];
        assign frame[HOUSE_TOP - 2*i - 1] = ~hp[HOUSE_W-1-i];
    end

    for (genvar j = 0; j < KEY_W; j++) begin : g_key_pair
        assign frame[KEY_TOP - 2*j]     =  kp[KEY_W-1-j];
        assign frame[KEY_TOP - 2*j - 1] = ~kp[KEY_W-1-j];
    end

endmodule

// File: rtl/plc_frame_tx.sv
module plc_frame_tx
    import plc_tx_pkg::*;
#(
    parameter int HALF_US         = 8333,
    parameter int BURST_US        = 1000,
    parameter int SYNC_MIN_US     = 100,
    parameter int SYNC_TIMEOUT_US = 250000,
    parameter int SYNC_TRIES      = 10,
    parameter int GUARD_ZC        = 6,
    parameter int SYNC_STAGES     = 2,
    parameter int CODE_W          = 8,
    parameter int REP_W           = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zc_in,
    input  logic              us_tick,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [CODE_W-1:0] cmd_house,
    input  logic [CODE_W-1:0] cmd_key,
    input  logic [REP_W-1:0]  cmd_reps,
    output logic              carrier_en,
    output logic              busy,
    output logic              done,
    output logic              error
);
    localparam int MIN_GAP_US = HALF_US * 72 / 100;
    localparam int MAX_GAP_US = HALF_US * 102 / 100;
    localparam int CNT_LIMIT  = (SYNC_TIMEOUT_US > MAX_GAP_US) ? SYNC_TIMEOUT_US : MAX_GAP_US + 1;
    localparam int CNT_W      = $clog2(CNT_LIMIT + 1);
    localparam int TRY_W      = $clog2(SYNC_TRIES + 1);
    localparam int GUARD_W    = $clog2(GUARD_ZC + 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);

    // crossing detection and interval timing
    logic             zc_edge;
    logic             tmr_clr;
    logic [CNT_W-1:0] gap;

    plc_zc_sync #(.STAGES(SYNC_STAGES)) u_zc (
        .clk      (clk),
        .rst_n    (rst_n),
        .zc_async (zc_in),
        .zc_edge  (zc_edge)
    );

    plc_gap_timer #(.LIMIT(CNT_LIMIT), .CNT_W(CNT_W)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (us_tick),
        .clear (tmr_clr | zc_edge),
        .gap   (gap)
    );

    // control state
    tx_state_e          state, state_d;
    logic [TRY_W-1:0]   try_cnt, try_d;
    logic [GUARD_W-1:0] guard_cnt, guard_d;
    logic [SLOT_W-1:0]  slot_idx, slot_d;
    logic [REP_W-1:0]   rep_left, rep_d;
    logic [HOUSE_W-1:0] house_q, house_d;
    logic [KEY_W-1:0]   key_q, key_d;

    logic [FRAME_SLOTS-1:0] frame_bits;

    plc_frame_encoder u_enc (
        .house (house_q),
        .key   (key_q),
        .frame (frame_bits)
    );

    logic cmd_bad;
    logic gap_early, gap_late, sync_late, sync_ok, burst_win;

    assign cmd_bad   = ((cmd_house >> HOUSE_W) != '0) || ((cmd_key >> KEY_W) != '0) ||
                       (cmd_reps == '0);
    assign gap_early = gap < CNT_W'(MIN_GAP_US);
    assign gap_late  = gap > CNT_W'(MAX_GAP_US);
    assign sync_ok   = gap >= CNT_W'(SYNC_MIN_US);
    assign sync_late = gap >= CNT_W'(SYNC_TIMEOUT_US);
    assign burst_win = gap < CNT_W'(BURST_US);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            try_cnt   <= '0;
            guard_cnt <= '0;
            slot_idx  <= '0;
            rep_left  <= '0;
            house_q   <= '0;
            key_q     <= '0;
        end else begin
            state     <= state_d;
            try_cnt   <= try_d;
            guard_cnt <= guard_d;
            slot_idx  <= slot_d;
            rep_left  <= rep_d;
            house_q   <= house_d;
            key_q     <= key_d;
        end
    end

    // next state
    always_comb begin
        state_d = state;
        try_d   = try_cnt;
        guard_d = guard_cnt;
        slot_d  = slot_idx;
        rep_d   = rep_left;
        house_d = house_q;
        key_d   = key_q;
        tmr_clr = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_bad) begin
                        state_d = ST_FAIL;                  // reject
                    end else begin
                        state_d = ST_SYNC;                  // accept
                        house_d = cmd_house[HOUSE_W-1:0];
                        key_d   = cmd_key[KEY_W-1:0];
                        rep_d   = cmd_reps;
                        try_d   = '0;
                        tmr_clr = 1'b1;
                    end
                end
            end
            ST_SYNC: begin
                if (zc_edge && sync_ok) begin
                    state_d = ST_GUARD;                     // lock
                    guard_d = '0;
                end else if (zc_edge || sync_late) begin
                    tmr_clr = 1'b1;
                    if (try_cnt == TRY_W'(SYNC_TRIES - 1)) begin
                        state_d = ST_FAIL;                  // sync_lost
                    end else begin
                        try_d = try_cnt + 1'b1;             // retry
                    end
                end
            end
            ST_GUARD: begin
                if (zc_edge) begin
                    if (gap_early) begin
                        state_d = ST_FAIL;                  // frame_err
                    end else if (guard_cnt == GUARD_W'(GUARD_ZC - 1)) begin
                        state_d = ST_SLOT;                  // gap_done
                        slot_d  = '0;
                    end else begin
                        guard_d = guard_cnt + 1'b1;
                    end
                end else if (gap_late) begin
                    state_d = ST_FAIL;                      // frame_err
                end
            end
            ST_SLOT: begin
                if (zc_edge) begin
                    if (gap_early) begin
                        state_d = ST_FAIL;                  // frame_err
                    end else if (slot_idx == LAST_SLOT) begin
                        if (rep_left == REP_W'(1)) begin
                            state_d = ST_FIN;               // last_slot
                        end else begin
                            rep_d  = rep_left - 1'b1;       // next_slot, new repeat
                            slot_d = '0;
                        end
                    end else begin
                        slot_d = slot_idx + 1'b1;           // next_slot
                    end
                end else if (gap_late) begin
                    state_d = ST_FAIL;                      // frame_err
                end
            end
            ST_FIN:  state_d = ST_IDLE;                     // release
            ST_FAIL: state_d = ST_IDLE;                     // release
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready  = (state == ST_IDLE);
        busy       = (state == ST_SYNC) || (state == ST_GUARD) || (state == ST_SLOT);
        done       = (state == ST_FIN);
        error      = (state == ST_FAIL);
        carrier_en = (state == ST_SLOT) && frame_bits[LAST_SLOT - slot_idx] && burst_win;
    end

endmodule

// File: rtl/plc_frame_tx_chk.sv
module plc_frame_tx_chk #(
    parameter int CODE_W = 8,
    parameter int REP_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [CODE_W-1:0] cmd_house,
    input logic [CODE_W-1:0] cmd_key,
    input logic [REP_W-1:0]  cmd_reps,
    input logic              carrier_en,
    input logic              busy,
    input logic              done,
    input logic              error
);
    logic bad_cmd;
    assign bad_cmd = (cmd_house > CODE_W'(15)) || (cmd_key > CODE_W'(31)) || (cmd_reps == '0);

    AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !busy);                                                  // R1
    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !bad_cmd) |=> busy);                        // R1
    AST_REJECT_ERRORS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && bad_cmd) |=> (error && !busy));             // R2
    AST_CARRIER_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_en |-> busy);                                                  // R8
    AST_ERROR_NO_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !carrier_en);                                                // R10
    AST_ERROR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);                                                     // R10
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                       // R11
    AST_DONE_ERROR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));                                                     // R11

endmodule

bind plc_frame_tx plc_frame_tx_chk #(.CODE_W(CODE_W), .REP_W(REP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_house  (cmd_house),
    .cmd_key    (cmd_key),
    .cmd_reps   (cmd_reps),
    .carrier_en (carrier_en),
    .busy       (busy),
    .done       (done),
    .error      (error)
);

// File: tb/plc_frame_tx_tb.sv
module plc_frame_tx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_US    = 100;
    localparam int BURST_US   = 10;
    localparam int SYNC_MIN   = 20;
    localparam int SYNC_TMO   = 150;
    localparam int TRIES      = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       zc_in = 1'b0;
    logic       us_tick = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_house = '0;
    logic [7:0] cmd_key = '0;
    logic [7:0] cmd_reps = '0;
    logic       cmd_ready, carrier_en, busy, done, error;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  zc_half = 200;
    bit  zc_run  = 1'b1;
    bit  exp_q[$];
    event zc_evt;

    plc_frame_tx #(
        .HALF_US(HALF_US), .BURST_US(BURST_US), .SYNC_MIN_US(SYNC_MIN),
        .SYNC_TIMEOUT_US(SYNC_TMO), .SYNC_TRIES(TRIES)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .zc_in(zc_in), .us_tick(us_tick),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_house(cmd_house),
        .cmd_key(cmd_key), .cmd_reps(cmd_reps), .carrier_en(carrier_en),
        .busy(busy), .done(done), .error(error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // microsecond strobe: one clock high in every two
    initial forever begin
        @(negedge clk);
        us_tick = ~us_tick;
    end

    // mains crossing source, both edges
    initial forever begin
        @(negedge clk);
        repeat (zc_half - 1) @(negedge clk);
        if (zc_run) begin
            zc_in = ~zc_in;
            ->zc_evt;
        end
    end

    // expected line patterns, searched from the pattern->code view
    function automatic int house_pattern(input int h);
        int inv[16] = '{12, 4, 2, 10, 14, 6, 0, 8, 13, 5, 3, 11, 15, 7, 1, 9};
        for (int p = 0; p < 16; p++) if (inv[p] == h) return p;
        return -1;
    endfunction

    function automatic int key_pattern(input int k);
        int inv[32] = '{12, 16, 4, 17, 2, 18, 10, 19, 14, 20, 6, 21, 0, 22, 8, 23,
                        13, 24, 5, 25, 3, 26, 11, 27, 15, 28, 7, 29, 1, 30, 9, 31};
        for (int p = 0; p < 32; p++) if (inv[p] == k) return p;
        return -1;
    endfunction

    // monitor: one expected carrier level per crossing
    initial forever begin
        bit e;
        @(zc_evt);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            repeat (4) @(negedge clk);
            check(carrier_en === e, "R5/R6/R7/R8 slot level", int'(carrier_en), int'(e));
            repeat (40) @(negedge clk);
            check(carrier_en === 1'b0, "R8 burst ended", int'(carrier_en), 0);
        end
    end

    task automatic issue(input int h, input int k, input int r);
        cmd_house = 8'(h); cmd_key = 8'(k); cmd_reps = 8'(r);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // driver: push expected per-crossing levels, then send
    task automatic send_ok(input int h, input int k, input int r, input bit poke);
        int  hp, kp;
        bit  got_done, got_err;
        @(zc_evt);
        @(negedge clk);
        hp = house_pattern(h);
        kp = key_pattern(k);
        for (int g = 0; g < 6; g++) exp_q.push_back(1'b0);          // R4 sync + guard
        for (int rr = 0; rr < r; rr++) begin                           // R9
            exp_q.push_back(1'b1); exp_q.push_back(1'b1);
            exp_q.push_back(1'b1); exp_q.push_back(1'b0);
            for (int b = 3; b >= 0; b--) begin
                exp_q.push_back(hp[b]); exp_q.push_back(!hp[b]);
            end
            for (int b = 4; b >= 0; b--) begin
                exp_q.push_back(kp[b]); exp_q.push_back(!kp[b]);
            end
        end
        exp_q.push_back(1'b0);                                          // closing crossing
        issue(h, k, r);
        check(busy === 1'b1 && cmd_ready === 1'b0, "R11 busy after accept", int'(busy), 1);
        if (poke) begin
            repeat (3) @(zc_evt);
            @(negedge clk);
            check(cmd_ready === 1'b0, "R1 not ready while busy", int'(cmd_ready), 0);
            issue(3, 5, 1);                                             // R1 must be ignored
        end
        got_done = 0; got_err = 0;
        for (int i = 0; i < 20000 && !got_done && !got_err; i++) begin
            @(negedge clk);
            got_done = done;
            got_err  = error;
        end
        check(got_done && !got_err, "R11 done pulse", int'(got_done), 1);
        @(negedge clk);
        check(done === 1'b0 && cmd_ready === 1'b1, "R11 done one cycle", int'(done), 0);
        repeat (50) @(negedge clk);
        check(exp_q.size() == 0, "R9 all slots sent", exp_q.size(), 0);
    endtask

    task automatic reject(input int h, input int k, input int r, input string req);
        @(negedge clk);
        issue(h, k, r);
        check(error === 1'b1 && busy === 1'b0, req, int'(error), 1);
        @(negedge clk);
        check(error === 1'b0 && cmd_ready === 1'b1 && carrier_en === 1'b0, req, int'(error), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit seen;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready === 1'b1 && busy === 1'b0, "R1 reset idle", int'(cmd_ready), 1);
        check(carrier_en === 1'b0 && done === 1'b0 && error === 1'b0, "R11 reset outputs",
              int'(carrier_en), 0);

        send_ok(0, 0, 2, 1'b1);      // R5 R6 R7 R9 R1 R12
        send_ok(15, 31, 1, 1'b0);    // R6 R7 top codes
        send_ok(12, 16, 3, 1'b0);    // R7 boundary key, R9 three repeats
        send_ok(9, 28, 1, 1'b0);     // R7 upper key group

        reject(16, 0, 2, "R2 house 16 rejected");
        reject(0, 32, 2, "R2 key 32 rejected");
        reject(2, 3, 0, "R2 zero repeats rejected");

        // R10 early crossing in slot 3
        @(zc_evt); @(negedge clk);
        issue(4, 4, 1);
        repeat (10) @(zc_evt);
        zc_half = 100;
        seen = 0;
        for (int i = 0; i < 150 && !seen; i++) begin
            @(negedge clk);
            seen = error;
            if (seen) check(carrier_en === 1'b0, "R10 carrier dropped", int'(carrier_en), 0);
        end
        check(seen, "R10 early crossing aborts", int'(seen), 1);
        zc_half = 200;
        @(negedge clk);
        check(cmd_ready === 1'b1 && done === 1'b0, "R10 back to idle", int'(cmd_ready), 1);

        // R10 missing crossing in slot 5
        @(zc_evt); @(negedge clk);
        issue(1, 2, 1);
        repeat (12) @(zc_evt);
        zc_run = 0;
        seen = 0;
        for (int i = 0; i < 180; i++) begin
            @(negedge clk);
            if (error) seen = 1;
        end
        check(!seen, "R10 no fault before upper limit", int'(seen), 0);
        for (int i = 0; i < 80 && !seen; i++) begin
            @(negedge clk);
            seen = error;
        end
        check(seen, "R10 late crossing aborts", int'(seen), 1);

        // R3 stuck crossing input: retries then failure
        @(negedge clk);
        issue(5, 6, 2);
        seen = 0;
        for (int i = 0; i < 2900; i++) begin
            @(negedge clk);
            if (error || !busy) seen = 1;
        end
        check(!seen, "R3 busy during sync retries", int'(seen), 0);
        for (int i = 0; i < 300 && !seen; i++) begin
            @(negedge clk);
            seen = error;
        end
        check(seen, "R3 sync failure reported", int'(seen), 1);
        check(carrier_en === 1'b0, "R3 no carrier on sync failure", int'(carrier_en), 0);
        zc_run = 1;

        send_ok(7, 20, 1, 1'b0);     // recovers after failures
        finish_run();
    end

endmodule